// File: doc/BRIEF.md
# Priority Queue Express/Preempt Steering

This block decides, for each of eight traffic priorities, whether frames of that priority go to the express queue or to the preemptable queue. Software supplies a requested 8-bit steering mask, one bit per priority. Each priority holds its own effective steering bit. That bit takes on the requested value only in a cycle when the priority has nothing queued. As a result, a priority never has frames in both queues at once, and frames of one priority are never reordered.

The requested mask is qualified by a preemption-verified flag. Until the link partner has confirmed preemption, the target for every priority is the express queue. For each enqueue request, the block reports the queue chosen for that frame one cycle later. It also exposes the effective mask, so software can see when a mask change has reached every priority. Queue storage and scheduling are outside this block.

Top module: `prio_steer`

## Requirements
- R1: After reset, `eff_mask` is all zeros (every priority goes to express), and `sel_valid` and `sel_preempt` are low.
- R2: A steering bit of 1 selects the preemptable queue and a bit of 0 selects the express queue. The cycle after an enqueue, `sel_preempt` equals the effective bit that the enqueued priority held in the enqueue cycle.
- R3: In any cycle where `prio_empty[i]` is high and no enqueue targets priority i, `eff_mask[i]` becomes `verified & req_mask[i]` on the next clock edge.
- R4: While `prio_empty[i]` is low, `eff_mask[i]` keeps its value, however `req_mask` changes.
- R5: While `verified` is low, an update as in R3 sets the effective bit to 0 (express), even if the requested bit is 1.
- R6: If an enqueue on priority i and a high `prio_empty[i]` fall in the same cycle, the enqueue uses the old bit and `eff_mask[i]` does not change in that cycle. The update happens in a later empty cycle.
- R7: Each priority updates independently. An update on one priority is not held back because another priority is busy.
- R8: `sel_valid` is high in exactly those cycles that follow a cycle with `enq_valid` high.
- R9: Priority p, given as the binary value p on `enq_prio`, corresponds to bit p of `req_mask`, `prio_empty` and `eff_mask`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_mask | input | 8 | Requested steering mask (1 = preemptable) |
| prio_empty | input | 8 | Per-priority indication that nothing is queued |
| verified | input | 1 | Preemption has been verified with the link partner |
| enq_valid | input | 1 | A frame is being enqueued this cycle |
| enq_prio | input | 3 | Priority of the enqueued frame |
| sel_valid | output | 1 | Queue selection valid (one cycle after enqueue) |
| sel_preempt | output | 1 | Selected queue: 1 preemptable, 0 express |
| eff_mask | output | 8 | Currently effective steering mask |

## Verification
The assertions check the following on every cycle:
- a busy priority holds its bit;
- a colliding enqueue defers the update;
- an unverified update always lands on express;
- an applied update copies the requested bit;
- selection valid follows enqueue by exactly one cycle;
- the enqueue decode is at most one-hot.

Some properties only the bench scenarios can show. These are the full mapping of all 256 mask values to per-priority queue choices, the independence of priorities during a partial drain, and the later completion of a deferred update. The bench also runs a long stretch of mixed traffic against its own model of the effective mask.

// File: rtl/steer_pkg.sv
package steer_pkg;
    typedef struct packed {
        logic valid;
        logic preempt;
    } sel_t;

    typedef struct packed {
        logic eff;
    } lane_t;
endpackage

// File: rtl/steer_decode.sv
module steer_decode #(
    parameter int NUM_PRIO = 8,
    localparam int PW = (NUM_PRIO > 1) ? $clog2(NUM_PRIO) : 1
) (
    input  logic                enq_valid,
    input  logic [PW-1:0]       enq_prio,
    output logic [NUM_PRIO-1:0] enq_hit
);
    // One-hot decode of the enqueued priority; out-of-range values hit nothing.
    for (genvar i = 0; i < NUM_PRIO; i++) begin : g_hit
        assign enq_hit[i] = enq_valid && (enq_prio == PW'(i));
    end
endmodule

// File: rtl/steer_lane.sv
module steer_lane
    import steer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_bit,
    input  logic empty,
    input  logic verified,
    input  logic enq_hit,
    output logic eff
);
    lane_t lane_d, lane_q;

    always_comb begin
        lane_d = lane_q;
        // Switch only when the priority holds no frames and none arrives now.
        if (empty && !enq_hit) begin
            lane_d.eff = verified & req_bit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lane_q <= '0;
        else        lane_q <= lane_d;
    end

    assign eff = lane_q.eff;

    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !empty |=> $stable(eff)); // R4
    AST_COLLIDE_DEFER: assert property (@(posedge clk) disable iff (!rst_n)
        enq_hit |=> $stable(eff)); // R6
    AST_UNVERIFIED_EXPRESS: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !enq_hit && !verified) |=> !eff); // R5
    AST_APPLY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !enq_hit && verified) |=> (eff == $past(req_bit))); // R3
endmodule

// File: rtl/steer_select.sv
module steer_select
    import steer_pkg::*;
#(
    parameter int NUM_PRIO = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enq_valid,
    input  logic [NUM_PRIO-1:0] enq_hit,
    input  logic [NUM_PRIO-1:0] eff_mask,
    output logic                sel_valid,
    output logic                sel_preempt
);
    sel_t sel_d, sel_q;

    always_comb begin
        sel_d.valid   = enq_valid;
        // Uses the mapping in force during the enqueue cycle.
        sel_d.preempt = enq_valid && |(enq_hit & eff_mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sel_q <= '0;
        else        sel_q <= sel_d;
    end

    assign sel_valid   = sel_q.valid;
    assign sel_preempt = sel_q.preempt;

    AST_SEL_FOLLOWS_ENQ: assert property (@(posedge clk) disable iff (!rst_n)
        enq_valid |=> sel_valid); // R8
    AST_SEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !enq_valid |=> !sel_valid); // R8
    AST_SEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_valid |-> !sel_preempt); // R2
endmodule

// File: rtl/prio_steer.sv
module prio_steer #(
    parameter int NUM_PRIO = 8,
    localparam int PW = (NUM_PRIO > 1) ? $clog2(NUM_PRIO) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PRIO-1:0] req_mask,
    input  logic [NUM_PRIO-1:0] prio_empty,
    input  logic                verified,
    input  logic                enq_valid,
    input  logic [PW-1:0]       enq_prio,
    output logic                sel_valid,
    output logic                sel_preempt,
    output logic [NUM_PRIO-1:0] eff_mask
);
    logic [NUM_PRIO-1:0] enq_hit;

    steer_decode #(.NUM_PRIO(NUM_PRIO)) u_decode (
        .enq_valid (enq_valid),
        .enq_prio  (enq_prio),
        .enq_hit   (enq_hit)
    );

    for (genvar i = 0; i < NUM_PRIO; i++) begin : g_lane
        steer_lane u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .req_bit  (req_mask[i]),
            .empty    (prio_empty[i]),
            .verified (verified),
            .enq_hit  (enq_hit[i]),
            .eff      (eff_mask[i])
        );
    end

    steer_select #(.NUM_PRIO(NUM_PRIO)) u_select (
        .clk         (clk),
        .rst_n       (rst_n),
        .enq_valid   (enq_valid),
        .enq_hit     (enq_hit),
        .eff_mask    (eff_mask),
        .sel_valid   (sel_valid),
        .sel_preempt (sel_preempt)
    );

    AST_DECODE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(enq_hit)); // R9
    AST_NO_ENQ_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        !enq_valid |-> (enq_hit == '0)); // R9
endmodule

// File: tb/test_prio_steer.sv
module test_prio_steer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] req_mask = '0;
    logic [7:0] prio_empty = '0;
    logic       verified = 1'b0;
    logic       enq_valid = 1'b0;
    logic [2:0] enq_prio = '0;
    logic       sel_valid, sel_preempt;
    logic [7:0] eff_mask;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    logic [7:0] exp_eff = '0;

    always #2 clk = ~clk;

    prio_steer i_prio_steer (
        .clk(clk), .rst_n(rst_n), .req_mask(req_mask), .prio_empty(prio_empty),
        .verified(verified), .enq_valid(enq_valid), .enq_prio(enq_prio),
        .sel_valid(sel_valid), .sel_preempt(sel_preempt), .eff_mask(eff_mask)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            fails = fails + 1;
            tests = tests + 1;
            $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests = tests + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Drive one cycle at the negative edge, model the requirements, check at the next negative edge.
    task automatic step(input string tag, input logic [7:0] rq, input logic [7:0] em,
                        input logic vf, input logic ev, input logic [2:0] ep);
        logic       exp_pre;
        req_mask = rq; prio_empty = em; verified = vf; enq_valid = ev; enq_prio = ep;
        exp_pre = ev & exp_eff[ep];
        for (int i = 0; i < 8; i++) begin
            if (em[i] && !(ev && ep == 3'(i))) exp_eff[i] = vf & rq[i];
        end
        @(negedge clk);
        check({tag, " eff_mask"}, 32'(eff_mask), 32'(exp_eff));
        check({tag, " sel_valid"}, 32'(sel_valid), 32'(ev));
        check({tag, " sel_preempt"}, 32'(sel_preempt), 32'(exp_pre));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 eff_mask", 32'(eff_mask), 32'h0);
        check("R1 sel_valid", 32'(sel_valid), 32'h0);
        check("R1 sel_preempt", 32'(sel_preempt), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 post-release eff_mask", 32'(eff_mask), 32'h0);

        // R3, R2, R9: sweep every mask, then enqueue each priority with queues busy.
        for (int m = 0; m < 256; m++) begin
            step("R3 sweep", 8'(m), 8'hFF, 1'b1, 1'b0, 3'd0);
            check("R3 sweep mask", 32'(eff_mask), 32'(m));
            for (int p = 0; p < 8; p++) begin
                step("R2 R9 select", 8'(~m), 8'h00, 1'b1, 1'b1, 3'(p));
            end
        end

        // R5: unverified forces express.
        step("R5 unverified", 8'hFF, 8'hFF, 1'b0, 1'b0, 3'd0);
        check("R5 all express", 32'(eff_mask), 32'h0);

        // R4: busy priorities hold while the request changes.
        step("R4 setup", 8'hAA, 8'hFF, 1'b1, 1'b0, 3'd0);
        for (int k = 0; k < 4; k++) step("R4 busy hold", 8'h55, 8'h00, 1'b1, 1'b0, 3'd0);
        check("R4 held", 32'(eff_mask), 32'hAA);

        // R7: partial drain updates only the empty priorities.
        step("R7 partial", 8'h55, 8'h0F, 1'b1, 1'b0, 3'd0);
        check("R7 low nibble only", 32'(eff_mask), 32'hA5);

        // R6: collision defers, later empty cycle completes the switch.
        step("R6 clear", 8'h00, 8'hFF, 1'b1, 1'b0, 3'd0);
        step("R6 collide", 8'hFF, 8'hFF, 1'b1, 1'b1, 3'd3);
        check("R6 deferred bit", 32'(eff_mask), 32'hF7);
        check("R6 old mapping used", 32'(sel_preempt), 32'h0);
        step("R6 complete", 8'hFF, 8'hFF, 1'b1, 1'b0, 3'd0);
        check("R6 completed", 32'(eff_mask), 32'hFF);

        // R8: idle gives no selection.
        step("R8 idle", 8'hFF, 8'h00, 1'b1, 1'b0, 3'd5);
        check("R8 idle low", 32'(sel_valid), 32'h0);

        // Mixed traffic against the model.
        for (int n = 0; n < 3000; n++) begin
            step("R3 mixed", 8'($urandom), 8'($urandom), ($urandom % 4) != 0,
                 1'($urandom), 3'($urandom));
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule